// File: doc/BRIEF.md
# External DMA Request Acceptance Unit

This block sits between an external requesting device and a four-channel DMA engine. It decodes transfer requests into per-channel pending requests. Each request strobe is sampled on a clock edge. The strobe may come with a request descriptor naming a channel, a mode and a size. It may also come with no descriptor, in which case the most recently named channel is requested again. It may instead come together with a data-bus request line, which marks a direct transfer on channel 2.

Channels 1 to 3 each hold a small FIFO of pending requests. Each FIFO entry records whether the request was a direct transfer. The channel's engine consumes one entry per pulse on its pop input. Channel 0 has a single sticky request line instead of a queue, and that line respects the channel's busy status. A channel 0 request that arrives while the channel 0 transfer-end flag is set puts the unit into a frozen state. The unit leaves that state only after the flag is cleared.

Top module: `ext_dma_req_unit`

## Requirements
- R1: After reset, no request is pending on any channel (pend_o = 0), frozen_o is 0 and bus_avail_o is 0.
- R2: When no descriptor has been accepted since reset, a strobe with no descriptor and no data-bus request is discarded and no channel is requested.
- R3: A strobe with desc_vld_i = 1 and desc_id_i equal to 1, 2 or 3 adds one request to that channel's queue. A later strobe with no descriptor requests that same channel again. pend_o[k] is high while channel k's queue is not empty.
- R4: A descriptor with desc_id_i = 0, desc_md_i = 0 and desc_sz_i not equal to 5 or 6 sets pend_o[0]. Any other descriptor with ID 0 is ignored. pop_i[0] clears pend_o[0].
- R5: A channel 0 request that arrives while ch0_busy_i = 1 is ignored.
- R6: Each queue holds 4 entries. A request aimed at a full queue is dropped silently. Each pop_i[k] pulse removes one entry, and a pop on an empty queue does nothing.
- R7: A push and a pop on the same channel in the same cycle, with the queue full, leaves the queue holding 4 entries.
- R8: A strobe together with dbus_req_i is a direct request for channel 2. It is queued with head_direct_o[2] = 1 and never raises bus_avail_o. dbus_req_i without the strobe raises bus_avail_o in the following cycle.
- R9: A direct request for channel 2 is accepted only while the channel 2 queue has a free entry.
- R10: A channel 0 request that arrives while ch0_end_flag_i = 1 sets frozen_o and is not recorded. While frozen, every strobe is ignored. frozen_o clears one cycle after ch0_end_flag_i drops.
- R11: A descriptor that decodes to no channel leaves the remembered channel unchanged. A direct request also leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Request strobe, one cycle per request |
| dbus_req_i | input | 1 | Data-bus request line |
| desc_vld_i | input | 1 | Descriptor accompanies the strobe |
| desc_id_i | input | 2 | Descriptor channel field |
| desc_md_i | input | 2 | Descriptor mode field |
| desc_sz_i | input | 3 | Descriptor size field |
| ch0_busy_i | input | 1 | Channel 0 bus cycle in progress |
| ch0_end_flag_i | input | 1 | Channel 0 transfer-end flag |
| pop_i | input | 4 | Per-channel request-consumed pulse |
| pend_o | output | 4 | Per-channel request pending |
| head_direct_o | output | 4 | Oldest queued entry is a direct transfer (bit 0 is always 0) |
| bus_avail_o | output | 1 | Bus-available indication for a plain data-bus request |
| frozen_o | output | 1 | Unit is frozen |

## Verification
Each test applies a different kind of strobe and checks that it lands on the right channel. The kinds are a descriptor naming a channel, a bare repeat, and a strobe paired with the data-bus line. Channel 0 descriptors are tried with the mode field nonzero and with each excluded size code, which separates the valid decode from the near misses. Queue depth is measured by overfilling and then counting the pops needed to empty the queue. That count shows whether overflow entries were dropped and whether a push and pop together on a full queue keep the queue full. The freeze test checks that strobes have no effect while the end flag stays set, and that the unit recovers after the flag clears.

// File: rtl/edr_pkg.sv
package edr_pkg;
  localparam int NUM_CH  = 4;
  localparam int QDEPTH  = 4;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int MD_W    = 2;
  localparam int SZ_W    = 3;
  localparam int DIRECT_CH = 2;
  localparam logic [SZ_W-1:0] SZ_BAD_A = 3'd5;
  localparam logic [SZ_W-1:0] SZ_BAD_B = 3'd6;

  typedef struct packed {
    logic [CH_W-1:0] id;
    logic [MD_W-1:0] md;
    logic [SZ_W-1:0] sz;
  } req_desc_t;
endpackage

// File: rtl/edr_decode.sv
module edr_decode
  import edr_pkg::*;
(
  input  logic            strobe,
  input  logic            dbus_req,
  input  logic            desc_vld,
  input  req_desc_t       desc,
  input  logic            last_vld,
  input  logic [CH_W-1:0] last_ch,
  input  logic            frozen,
  output logic            hit,
  output logic [CH_W-1:0] tgt_ch,
  output logic            tgt_direct,
  output logic            upd_last
);
  logic act;
  logic ch0_ok;

  assign act    = strobe & ~frozen;
  assign ch0_ok = (desc.md == '0) && (desc.sz != SZ_BAD_A) && (desc.sz != SZ_BAD_B);

  always_comb begin
    hit        = 1'b0;
    tgt_ch     = '0;
    tgt_direct = 1'b0;
    upd_last   = 1'b0;
    if (act && dbus_req) begin
      hit        = 1'b1;
      tgt_ch     = CH_W'(DIRECT_CH);
      tgt_direct = 1'b1;
    end else if (act && desc_vld) begin
      if (desc.id != '0) begin
        hit      = 1'b1;
        tgt_ch   = desc.id;
        upd_last = 1'b1;
      end else if (ch0_ok) begin
        hit      = 1'b1;
        tgt_ch   = '0;
        upd_last = 1'b1;
      end
    end else if (act && last_vld) begin
      hit    = 1'b1;
      tgt_ch = last_ch;
    end
  end

  // R2: a bare strobe before any descriptor never hits
  always_comb begin
    p_first_bare_ignored_r2: assert (!(strobe && !dbus_req && !desc_vld && !last_vld) || !hit);
  end
endmodule

// File: rtl/edr_fifo.sv
module edr_fifo #(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic push_tag,
  input  logic pop,
  output logic not_empty,
  output logic head_tag
);
  logic [DEPTH-1:0] tag_q, tag_d;
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic full, do_pop, do_push;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_pop  = pop && (cnt_q != '0);
  assign do_push = push && (!full || do_pop);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    tag_d = tag_q;
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) begin
      tag_d[wr_q] = push_tag;
      wr_d        = bump(wr_q);
    end
    if (do_pop) rd_d = bump(rd_q);
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      tag_q <= tag_d;
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  assign not_empty = (cnt_q != '0);
  assign head_tag  = not_empty & tag_q[rd_q];

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (cnt_q == CNT_W'(DEPTH)));
  p_full_pushpop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop) |=> (cnt_q == CNT_W'(DEPTH)));
  p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_empty && pop && !push) |=> !not_empty);
endmodule

// File: rtl/edr_line.sv
module edr_line (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic busy,
  input  logic pop,
  output logic pend
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (pop) pend_d = 1'b0;
    if (req && !busy) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  p_busy_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pend_q) |=> !pend_q);
endmodule

// File: rtl/ext_dma_req_unit.sv
module ext_dma_req_unit
  import edr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic              dbus_req_i,
  input  logic              desc_vld_i,
  input  logic [CH_W-1:0]   desc_id_i,
  input  logic [MD_W-1:0]   desc_md_i,
  input  logic [SZ_W-1:0]   desc_sz_i,
  input  logic              ch0_busy_i,
  input  logic              ch0_end_flag_i,
  input  logic [NUM_CH-1:0] pop_i,
  output logic [NUM_CH-1:0] pend_o,
  output logic [NUM_CH-1:0] head_direct_o,
  output logic              bus_avail_o,
  output logic              frozen_o
);
  req_desc_t       desc;
  logic            hit, tgt_direct, upd_last;
  logic [CH_W-1:0] tgt_ch;
  logic            last_vld_q, last_vld_d;
  logic [CH_W-1:0] last_ch_q, last_ch_d;
  logic            frozen_q, frozen_d;
  logic            bavl_q, bavl_d;
  logic            ch0_hit, freeze_set;
  logic [NUM_CH-1:0] push_vec;

  assign desc = '{id: desc_id_i, md: desc_md_i, sz: desc_sz_i};

  edr_decode u_dec (
    .strobe     (strobe_i),
    .dbus_req   (dbus_req_i),
    .desc_vld   (desc_vld_i),
    .desc       (desc),
    .last_vld   (last_vld_q),
    .last_ch    (last_ch_q),
    .frozen     (frozen_q),
    .hit        (hit),
    .tgt_ch     (tgt_ch),
    .tgt_direct (tgt_direct),
    .upd_last   (upd_last)
  );

  assign ch0_hit    = hit && (tgt_ch == '0);
  assign freeze_set = ch0_hit && ch0_end_flag_i;

  always_comb begin
    for (int k = 0; k < NUM_CH; k++) push_vec[k] = hit && (tgt_ch == CH_W'(k));
    push_vec[0] = ch0_hit && !ch0_end_flag_i;
  end

  always_comb begin
    last_vld_d = last_vld_q;
    last_ch_d  = last_ch_q;
    if (upd_last) begin
      last_vld_d = 1'b1;
      last_ch_d  = tgt_ch;
    end
    frozen_d = frozen_q ? ch0_end_flag_i : freeze_set;
    bavl_d   = dbus_req_i && !strobe_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_vld_q <= 1'b0;
      last_ch_q  <= '0;
      frozen_q   <= 1'b0;
      bavl_q     <= 1'b0;
    end else begin
      last_vld_q <= last_vld_d;
      last_ch_q  <= last_ch_d;
      frozen_q   <= frozen_d;
      bavl_q     <= bavl_d;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    if (g == 0) begin : g_line
      edr_line u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (push_vec[g]),
        .busy  (ch0_busy_i),
        .pop   (pop_i[g]),
        .pend  (pend_o[g])
      );
      assign head_direct_o[g] = 1'b0;
    end else begin : g_q
      edr_fifo #(.DEPTH(QDEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_vec[g]),
        .push_tag  (tgt_direct),
        .pop       (pop_i[g]),
        .not_empty (pend_o[g]),
        .head_tag  (head_direct_o[g])
      );
    end
  end

  assign bus_avail_o = bavl_q;
  assign frozen_o    = frozen_q;

  p_no_bus_avail_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && dbus_req_i) |=> !bus_avail_o);
  p_freeze_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen_q && ch0_end_flag_i) |=> frozen_q);
  p_freeze_no_ch0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_set && !pend_o[0] && !pop_i[0]) |=> !pend_o[0]);
  p_frozen_no_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q |-> !hit);
  p_direct_keeps_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_direct && !desc_vld_i) |=> $stable(last_ch_q) && $stable(last_vld_q));
endmodule

// File: tb/ext_dma_req_unit_test.sv
`timescale 1ns/1ps
module ext_dma_req_unit_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       strobe_i, dbus_req_i, desc_vld_i;
  logic [1:0] desc_id_i, desc_md_i;
  logic [2:0] desc_sz_i;
  logic       ch0_busy_i, ch0_end_flag_i;
  logic [3:0] pop_i;
  logic [3:0] pend_o, head_direct_o;
  logic       bus_avail_o, frozen_o;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ext_dma_req_unit uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_pend(input string tag, input logic [3:0] exp);
    chk(pend_o === exp, tag, int'(pend_o), int'(exp));
  endtask

  task automatic send(input bit st, input bit db, input bit dv,
                      input logic [1:0] id, input logic [1:0] md, input logic [2:0] sz,
                      input logic [3:0] pp);
    strobe_i = st; dbus_req_i = db; desc_vld_i = dv;
    desc_id_i = id; desc_md_i = md; desc_sz_i = sz; pop_i = pp;
    @(negedge clk);
    strobe_i = 0; dbus_req_i = 0; desc_vld_i = 0; pop_i = '0;
  endtask

  task automatic req(input logic [1:0] id, input logic [1:0] md, input logic [2:0] sz);
    send(1, 0, 1, id, md, sz, '0);
  endtask
  task automatic bare();   send(1, 0, 0, 0, 0, 0, '0); endtask
  task automatic direct(); send(1, 1, 0, 0, 0, 0, '0); endtask
  task automatic pop(input logic [3:0] m); send(0, 0, 0, 0, 0, 0, m); endtask

  task automatic do_reset();
    rst_n = 0;
    strobe_i = 0; dbus_req_i = 0; desc_vld_i = 0;
    desc_id_i = 0; desc_md_i = 0; desc_sz_i = 0;
    ch0_busy_i = 0; ch0_end_flag_i = 0; pop_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // pops channel k until empty, returns number of pops taken
  task automatic drain(input int k, output int n);
    n = 0;
    for (int i = 0; i < 8 && pend_o[k]; i++) begin
      pop(4'(1 << k));
      n++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk_pend("R1 pend after reset", 4'b0000);
    chk(frozen_o === 0, "R1 frozen after reset", frozen_o, 0);
    chk(bus_avail_o === 0, "R1 bus_avail after reset", bus_avail_o, 0);
  endtask

  task automatic t_first_bare();
    do_reset();
    bare();
    chk_pend("R2 first bare strobe ignored", 4'b0000);
  endtask

  task automatic t_repeat();
    int n;
    do_reset();
    req(2'd1, 2'd3, 3'd7);
    chk_pend("R3 id1 queued", 4'b0010);
    bare();
    drain(1, n);
    chk(n == 2, "R3 bare repeats channel 1", n, 2);
  endtask

  task automatic t_ch0_decode();
    do_reset();
    req(2'd0, 2'd1, 3'd0);
    chk_pend("R4 md!=0 ignored", 4'b0000);
    req(2'd0, 2'd0, 3'd5);
    chk_pend("R4 sz=5 ignored", 4'b0000);
    req(2'd0, 2'd0, 3'd6);
    chk_pend("R4 sz=6 ignored", 4'b0000);
    req(2'd0, 2'd0, 3'd4);
    chk_pend("R4 valid ch0 decode", 4'b0001);
    pop(4'b0001);
    chk_pend("R4 pop clears ch0", 4'b0000);
  endtask

  task automatic t_ch0_busy();
    do_reset();
    ch0_busy_i = 1;
    req(2'd0, 2'd0, 3'd0);
    ch0_busy_i = 0;
    chk_pend("R5 busy ch0 ignored", 4'b0000);
  endtask

  task automatic t_depth();
    int n;
    do_reset();
    for (int i = 0; i < 5; i++) req(2'd3, 2'd0, 3'd0);
    drain(3, n);
    chk(n == 4, "R6 depth 4 overflow dropped", n, 4);
    pop(4'b1000);
    chk_pend("R6 pop on empty harmless", 4'b0000);
    req(2'd3, 2'd0, 3'd0);
    drain(3, n);
    chk(n == 1, "R6 queue reusable after empty pop", n, 1);
  endtask

  task automatic t_full_pushpop();
    int n;
    do_reset();
    for (int i = 0; i < 4; i++) req(2'd1, 2'd0, 3'd0);
    send(1, 0, 1, 2'd1, 2'd0, 3'd0, 4'b0010);
    drain(1, n);
    chk(n == 4, "R7 push+pop on full keeps 4", n, 4);
  endtask

  task automatic t_direct();
    do_reset();
    direct();
    chk_pend("R8 direct goes to ch2", 4'b0100);
    chk(head_direct_o[2] === 1, "R8 direct tag", head_direct_o[2], 1);
    chk(bus_avail_o === 0, "R8 no bus_avail on direct", bus_avail_o, 0);
    send(0, 1, 0, 0, 0, 0, '0);
    chk(bus_avail_o === 1, "R8 bus_avail on plain dbus req", bus_avail_o, 1);
    chk_pend("R8 plain dbus req queues nothing", 4'b0100);
  endtask

  task automatic t_direct_full();
    int n;
    do_reset();
    for (int i = 0; i < 6; i++) direct();
    drain(2, n);
    chk(n == 4, "R9 direct dropped when ch2 full", n, 4);
  endtask

  task automatic t_freeze();
    do_reset();
    ch0_end_flag_i = 1;
    req(2'd0, 2'd0, 3'd0);
    chk(frozen_o === 1, "R10 frozen set", frozen_o, 1);
    chk_pend("R10 freezing request not recorded", 4'b0000);
    req(2'd1, 2'd0, 3'd0);
    direct();
    chk_pend("R10 strobes ignored while frozen", 4'b0000);
    ch0_end_flag_i = 0;
    @(negedge clk);
    chk(frozen_o === 0, "R10 frozen cleared", frozen_o, 0);
    req(2'd1, 2'd0, 3'd0);
    chk_pend("R10 accepts after unfreeze", 4'b0010);
  endtask

  task automatic t_last_keep();
    int n;
    do_reset();
    req(2'd3, 2'd0, 3'd0);
    req(2'd0, 2'd2, 3'd0);
    direct();
    bare();
    drain(3, n);
    chk(n == 2, "R11 last channel kept across invalid and direct", n, 2);
  endtask

  initial begin
    t_reset();
    t_first_bare();
    t_repeat();
    t_ch0_decode();
    t_ch0_busy();
    t_depth();
    t_full_pushpop();
    t_direct();
    t_direct_full();
    t_freeze();
    t_last_keep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule